// File: doc/BRIEF.md
# Page-hit memory acknowledge generator

This block produces the active-low data-transfer acknowledge that a CPU bus waits for on each access to a paged synchronous RAM. The RAM is built from pages of 512 sixteen-bit words. Consecutive accesses inside one page complete quickly. The first access after a move to a different page needs roughly 24 ns more than the usual 45 to 47 ns. The block keeps the page number of the last RAM access. It compares each new access against that number and acknowledges after a short fixed delay when the page matches. When the page differs, it adds one counted clock cycle to the delay.

An access begins on the first clock edge at which the address strobe is sampled low. That access belongs to the RAM only if the RAM chip-select is high on that same edge. At that point the block latches the page bits, decides hit or miss, and loads a countdown. The acknowledge asserts when the countdown expires. It stays asserted while the strobe stays low. The base delay for a hit is a parameter and may be zero, so one design serves several CPU clock rates.

Top module: `pagehit_ack`

## Requirements
- R1: After reset `ack_n` is high and no page is held, so the first RAM access after reset is treated as a page miss.
- R2: The page number of an access is `addr[21:9]`. Every RAM access replaces the held page number with its own page number.
- R3: A RAM access whose page equals the held page drives `ack_n` low after exactly BASE_WAIT further rising edges, counted from the edge that samples the start of the strobe.
- R4: A RAM access whose page differs from the held page, or that finds no page held, drives `ack_n` low after exactly BASE_WAIT+1 further rising edges.
- R5: Once low, `ack_n` stays low while `as_n` stays low. It returns high on the first rising edge that samples `as_n` high, and a new countdown is loaded only at the start of the next strobe.
- R6: A strobe with `ram_sel` low on its first edge produces no acknowledge and leaves the held page unchanged.
- R7: Address bits below bit 9 and above bit 21 have no effect on the hit or miss decision.
- R8: With BASE_WAIT set to 0, a page hit drives `ack_n` low on the edge that samples the start of the strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| as_n | input | 1 | Active-low address strobe; a low period is one access |
| ram_sel | input | 1 | High when the current access targets the RAM |
| addr | input | ADDR_W (24) | CPU address; bits 21..9 form the page number |
| ack_n | output | 1 | Active-low data-transfer acknowledge |

## Verification
The assertions assume that `as_n` returns high between accesses for at least one sampled edge. They also assume that `addr` and `ram_sel` are stable on the edge that samples the start of a strobe, because the hit decision and the tag load both use that edge alone. The stimulus drives all inputs on the falling clock edge and holds the address and select constant for the whole strobe. Each strobe stays low for at least two cycles longer than the longest miss delay and is followed by at least one high cycle. The pages are drawn from a small set, so hits and misses both occur often.

// File: rtl/pagehit_ack.sv
module pagehit_ack #(
  parameter int ADDR_W    = 24,
  parameter int PAGE_LO   = 9,
  parameter int PAGE_HI   = 21,
  parameter int BASE_WAIT = 2
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              as_n,
  input  logic              ram_sel,
  input  logic [ADDR_W-1:0] addr,
  output logic              ack_n
);
  localparam int PAGE_W = PAGE_HI - PAGE_LO + 1;
  localparam int CNT_W  = $clog2(BASE_WAIT + 2);
  localparam logic [CNT_W-1:0] BASE_V = CNT_W'(BASE_WAIT);

  logic [PAGE_W-1:0] tag;
  logic              tag_ok;
  logic              seen;
  logic              busy;
  logic [CNT_W-1:0]  cnt;

  wire [PAGE_W-1:0] page   = addr[PAGE_HI:PAGE_LO];
  wire              hit    = tag_ok && (tag == page);
  wire              start  = !as_n && !seen && ram_sel;
  wire [CNT_W-1:0]  wait_v = hit ? BASE_V : BASE_V + CNT_W'(1);
  wire              unused_addr = ^{addr[PAGE_LO-1:0], addr[ADDR_W-1:PAGE_HI+1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tag    <= '0;
      tag_ok <= 1'b0;
      seen   <= 1'b0;
      busy   <= 1'b0;
      cnt    <= '0;
      ack_n  <= 1'b1;
    end else if (as_n) begin
      seen  <= 1'b0;
      busy  <= 1'b0;
      cnt   <= '0;
      ack_n <= 1'b1;
    end else begin
      seen <= 1'b1;
      if (start) begin
        tag    <= page;
        tag_ok <= 1'b1;
        busy   <= 1'b1;
        cnt    <= wait_v;
        ack_n  <= (wait_v != '0);
      end else if (busy && cnt != '0) begin
        cnt <= cnt - CNT_W'(1);
        if (cnt == CNT_W'(1)) ack_n <= 1'b0;
      end
    end
  end

  AST_ACK_IN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_n |-> !$past(as_n)); // R5
  AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    as_n |=> ack_n); // R5
  AST_ACK_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_n |-> busy); // R6
  AST_TAG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (tag_ok && tag == $past(page))); // R2
  AST_UNSEL_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    (!as_n && !seen && !ram_sel) |=> $stable(tag)); // R6
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(BASE_WAIT + 1)); // R4
  AST_ZERO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (start && hit && BASE_WAIT == 0) |=> !ack_n); // R8
endmodule

// File: tb/pagehit_ack_test.sv
module pagehit_ack_test;
  localparam int B = 2;
  logic clk = 0, rst_n = 0, as_n = 1, ram_sel = 0;
  logic [23:0] addr = '0;
  logic ack_n, ack0_n;
  int vectors = 0, errors = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  pagehit_ack #(.BASE_WAIT(B)) uut (.clk, .rst_n, .as_n, .ram_sel, .addr, .ack_n(ack_n));
  pagehit_ack #(.BASE_WAIT(0)) uut0 (.clk, .rst_n, .as_n, .ram_sel, .addr, .ack_n(ack0_n));

  int m_tag [2];
  int m_rem [2];
  bit m_in  [2];
  bit m_seen;
  bit m_ack [2];

  always @(posedge clk) begin
    int pg;
    pg = int'(addr[21:9]);
    for (int i = 0; i < 2; i++) begin
      int base;
      base = (i == 0) ? B : 0;
      if (!rst_n) begin
        m_tag[i] = -1; m_rem[i] = 0; m_in[i] = 0; m_ack[i] = 1;
      end else if (as_n) begin
        m_in[i] = 0; m_ack[i] = 1;
      end else if (!m_seen) begin
        if (ram_sel) begin
          m_rem[i] = base + ((pg == m_tag[i]) ? 0 : 1);
          m_tag[i] = pg;
          m_in[i] = 1;
          if (m_rem[i] == 0) m_ack[i] = 0;
        end
      end else if (m_in[i] && m_rem[i] > 0) begin
        m_rem[i]--;
        if (m_rem[i] == 0) m_ack[i] = 0;
      end
    end
    m_seen = rst_n && !as_n;
  end

  always @(negedge clk) begin
    vectors += 2;
    if (ack_n !== m_ack[0]) begin
      errors++;
      $display("FAIL %s uut ack_n actual=%b expected=%b at %0t", cur_req, ack_n, m_ack[0], $time);
    end
    if (ack0_n !== m_ack[1]) begin
      errors++;
      $display("FAIL %s uut0 ack_n actual=%b expected=%b at %0t", cur_req, ack0_n, m_ack[1], $time);
    end
  end

  task automatic check(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic access(input logic [23:0] a, input logic sel, input int hold,
                        input int exp_lat, input int exp_lat0, input string req);
    int lat = -1, lat0 = -1;
    cur_req = req;
    addr = a; ram_sel = sel; as_n = 0;
    for (int k = 0; k < hold; k++) begin
      @(posedge clk); @(negedge clk);
      if (lat < 0 && !ack_n) lat = k;
      if (lat0 < 0 && !ack0_n) lat0 = k;
    end
    if (exp_lat >= 0) check({req, " latency base"}, lat, exp_lat);
    else check({req, " no ack base"}, lat, -1);
    if (exp_lat0 >= 0) check({req, " latency zero-base"}, lat0, exp_lat0);
    else check({req, " no ack zero-base"}, lat0, -1);
    if (exp_lat >= 0) check({req, " ack held to strobe end"}, int'(ack_n), 0);
    as_n = 1;
    @(posedge clk); @(negedge clk);
    check({req, " R5 release"}, int'(ack_n), 1);
    ram_sel = 0;
    @(posedge clk); @(negedge clk);
  endtask

  function automatic logic [23:0] mk(int hi, int page, int lo);
    return {hi[1:0], page[12:0], lo[8:0]};
  endfunction

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset ack", int'(ack_n), 1);
    rst_n = 1;
    @(negedge clk);
    access(mk(0, 5, 3), 1, B + 4, B + 1, 1, "R1 first access miss");
    access(mk(0, 5, 511), 1, B + 4, B, 0, "R3 same page hit");
    access(mk(3, 5, 0), 1, B + 4, B, 0, "R7 outer bits ignored");
    access(mk(0, 6, 7), 1, B + 4, B + 1, 1, "R4 new page miss");
    access(mk(0, 5, 7), 1, B + 4, B + 1, 1, "R2 tag replaced");
    access(mk(0, 6, 7), 0, B + 4, -1, -1, "R6 unselected access");
    access(mk(0, 5, 9), 1, B + 4, B, 0, "R6 tag kept");
    access(mk(0, 5, 1), 1, 12, B, 0, "R5 long strobe");
    access(mk(0, 8191, 0), 1, B + 4, B + 1, 1, "R2 top page miss");
    access(mk(1, 8191, 256), 1, B + 4, B, 0, "R8 zero-base hit");
    access(mk(0, 4095, 0), 1, B + 4, B + 1, 1, "R2 adjacent page bit");
    for (int n = 0; n < 400; n++) begin
      int p, s, e;
      p = (n % 7 == 0) ? 8191 : int'($urandom_range(10, 12));
      s = ($urandom_range(0, 5) != 0) ? 1 : 0;
      addr = mk(int'($urandom_range(0, 3)), p, int'($urandom_range(0, 511)));
      ram_sel = s[0]; as_n = 0;
      cur_req = "R3 R4 random";
      e = B + 4 + int'($urandom_range(0, 3));
      repeat (e) @(negedge clk);
      as_n = 1;
      repeat (1 + int'($urandom_range(0, 1))) @(negedge clk);
    end
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule